// File: doc/BRIEF.md
# CRC Signature Readout Register

This block gives user logic a serial path to two 32-bit CRC values kept by an error-detection engine. One value is the reference CRC, computed ahead of time. The other is the signature that the running calculation produced. Both arrive as parallel inputs. The block does not compute a CRC itself.

A 32-bit shift register captures either value in parallel and then streams it out one bit per clock on a single pin, least significant bit first. A shift/load control chooses between moving the register toward the output and loading it. A source select picks which value is loaded. A load takes effect only after the control has been low for two consecutive clock edges.

A registered flag goes high whenever the two CRC values disagree. All state changes on the rising clock edge. A synchronous active-high reset clears all state.

Top module: `crc_sig_readout`

## Requirements
- R1: A synchronous reset clears the shift register, the load-arming state and the mismatch flag. After reset, one low cycle of the shift/load control does not load the register.
- R2: `ser_out` always shows bit 0 of the shift register. A loaded value therefore appears least significant bit first.
- R3: While `shift_en` is 1, the register moves one bit toward `ser_out` on every rising edge, and zeros enter bit 31. After 32 shifts `ser_out` is 0.
- R4: A load with `src_sel` = 0 captures `golden_crc`.
- R5: A load with `src_sel` = 1 captures `sig_crc`.
- R6: The first edge with `shift_en` low only arms the load and leaves the register unchanged. The second consecutive low edge performs the load.
- R7: If `shift_en` returns to 1 after a single low edge, no load happens. The register keeps its contents and shifting continues from where it stopped.
- R8: While `shift_en` stays low past two edges, the register reloads on every edge. It follows the current value of the selected source and the current `src_sel`.
- R9: `src_sel` has no effect while `shift_en` is 1.
- R10: `mismatch` is registered. One edge after `golden_crc` and `sig_crc` differ it reads 1, and one edge after they are equal it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | 1: shift toward ser_out; 0: arm, then load |
| src_sel | input | 1 | Load source: 0 reference CRC, 1 signature |
| golden_crc | input | 32 | Precomputed reference CRC |
| sig_crc | input | 32 | Calculated CRC signature |
| ser_out | output | 1 | Bit 0 of the shift register |
| mismatch | output | 1 | Registered inequality of the two CRC inputs |

## Verification
The mismatch flag can update on the same edge as a parallel load. The source select can also change on the very edge where arming turns into loading. The bench changes the CRC inputs to unequal values while a load from one of them is in progress. It then checks the serialized word against the value present at the load edge, and checks the flag on that same edge. It also toggles `src_sel` on every shift edge and requires the stream to stay unchanged.

// File: rtl/crc_sig_readout.sv
module crc_sig_readout #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         src_sel,
  input  logic [W-1:0] golden_crc,
  input  logic [W-1:0] sig_crc,
  output logic         ser_out,
  output logic         mismatch
);

  logic [W-1:0] sr;
  logic         armed;
  logic [W-1:0] load_val;
  logic         do_load;

  assign load_val = src_sel ? sig_crc : golden_crc;
  assign do_load  = !shift_en && armed;
  assign ser_out  = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      armed    <= 1'b0;
      mismatch <= 1'b0;
    end else begin
      armed    <= !shift_en;
      mismatch <= (golden_crc != sig_crc);
      if (shift_en)
        sr <= {1'b0, sr[W-1:1]};
      else if (do_load)
        sr <= load_val;
    end
  end

  AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sr == ($past(sr) >> 1)); // R3

  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !armed) |=> $stable(sr)); // R6

  AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && armed) |=> sr == ($past(src_sel) ? $past(sig_crc) : $past(golden_crc))); // R8

  AST_MISMATCH_REG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mismatch == ($past(golden_crc) != $past(sig_crc))); // R10

endmodule

// File: tb/test_crc_sig_readout.sv
module test_crc_sig_readout;
  logic        clk = 1'b0;
  logic        rst;
  logic        shift_en;
  logic        src_sel;
  logic [31:0] golden_crc;
  logic [31:0] sig_crc;
  logic        ser_out;
  logic        mismatch;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc_sig_readout #(.W(32)) i_crc_sig_readout (
    .clk(clk), .rst(rst), .shift_en(shift_en), .src_sel(src_sel),
    .golden_crc(golden_crc), .sig_crc(sig_crc),
    .ser_out(ser_out), .mismatch(mismatch)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(logic sel);
    shift_en = 1'b0;
    src_sel  = sel;
    step();
    step();
  endtask

  task automatic read_word(output logic [31:0] w);
    shift_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      w[i] = ser_out;
      step();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; shift_en = 1'b0; src_sel = 1'b0;
    golden_crc = 32'h0000_0001; sig_crc = 32'h0000_0001;
    step(); step();
    check("R1 ser_out after reset", 32'(ser_out), 32'h0);
    check("R1 mismatch after reset", 32'(mismatch), 32'h0);
    rst = 1'b0;
    step();
    check("R1 no load on first low edge after reset", 32'(ser_out), 32'h0);
    shift_en = 1'b1;
    step();
  endtask

  task automatic t_golden();
    logic [31:0] w;
    golden_crc = 32'hA5C3_0F69; sig_crc = 32'h1234_5678;
    do_load(1'b0);
    check("R2 first bit is bit 0", 32'(ser_out), 32'h1);
    read_word(w);
    check("R4 golden word serialized", w, 32'hA5C3_0F69);
    check("R3 zero fill after 32 shifts", 32'(ser_out), 32'h0);
  endtask

  task automatic t_sig();
    logic [31:0] w;
    golden_crc = 32'h0; sig_crc = 32'hDEAD_BEEF;
    do_load(1'b1);
    read_word(w);
    check("R5 signature word serialized", w, 32'hDEAD_BEEF);
  endtask

  task automatic t_arm_only();
    golden_crc = 32'hFFFF_FFFF; sig_crc = 32'hFFFF_FFFF;
    shift_en = 1'b0; src_sel = 1'b0;
    step();
    check("R6 arming edge leaves register", 32'(ser_out), 32'h0);
    step();
    check("R6 second low edge loads", 32'(ser_out), 32'h1);
    shift_en = 1'b1;
    step();
  endtask

  task automatic t_single_low();
    logic [31:0] v = 32'b1010_0000_0000_0000_0000_0000_0001_0110;
    golden_crc = v;
    do_load(1'b0);
    shift_en = 1'b1;
    step(); step(); step();
    check("R7 bit 3 before glitch", 32'(ser_out), 32'(v[3]));
    golden_crc = 32'h0;
    shift_en = 1'b0;
    step();
    check("R7 held over single low edge", 32'(ser_out), 32'(v[3]));
    shift_en = 1'b1;
    step();
    check("R7 shifting resumes", 32'(ser_out), 32'(v[4]));
    step();
    check("R7 next bit", 32'(ser_out), 32'(v[5]));
  endtask

  task automatic t_long_low();
    logic [31:0] w;
    golden_crc = 32'h0000_0003; sig_crc = 32'h7777_0000;
    do_load(1'b0);
    check("R8 loaded golden", 32'(ser_out), 32'h1);
    golden_crc = 32'h0000_0002;
    step();
    check("R8 reload tracks golden", 32'(ser_out), 32'h0);
    src_sel = 1'b1; sig_crc = 32'h3C3C_5A5B;
    step();
    read_word(w);
    check("R8 reload follows new select", w, 32'h3C3C_5A5B);
  endtask

  task automatic t_sel_ignored();
    logic [31:0] w;
    golden_crc = 32'h0F1E_2D3C; sig_crc = 32'hFFFF_0000;
    do_load(1'b0);
    shift_en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      w[i] = ser_out;
      src_sel = ~src_sel;
      step();
    end
    check("R9 select ignored while shifting", w, 32'h0F1E_2D3C);
  endtask

  task automatic t_mismatch();
    logic [31:0] w;
    golden_crc = 32'h5555_AAAA; sig_crc = 32'h5555_AAAA;
    step();
    check("R10 equal gives 0", 32'(mismatch), 32'h0);
    sig_crc = 32'h5555_AAAB;
    #1;
    check("R10 not combinational", 32'(mismatch), 32'h0);
    shift_en = 1'b0; src_sel = 1'b1;
    step();
    check("R10 differ gives 1", 32'(mismatch), 32'h1);
    step();
    sig_crc = 32'h5555_AAAA;
    read_word(w);
    check("R10 load during mismatch captured signature", w, 32'h5555_AAAB);
    check("R10 equal again gives 0", 32'(mismatch), 32'h0);
  endtask

  initial begin
    t_reset();
    t_golden();
    t_sig();
    t_arm_only();
    t_single_low();
    t_long_low();
    t_sel_ignored();
    t_mismatch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule